// File: doc/BRIEF.md
# Posted Column Command Front End with DLL Lock Gate

This block sits at the device-side command input of a DDR2-style memory model. It watches a decoded command bus and takes extended mode register writes to set four things: whether the delay-locked loop is on, the additive latency applied to column commands, whether the data strobe is differential or single-ended, and whether reads use a separate strobe for the upper half of the data byte.

Read and write column commands may be sent early, before the row-to-column delay has elapsed. The block holds each one for the programmed additive latency and then presents it, with its bank and address, on an internal column command port. Whenever the delay-locked loop is switched on, by a mode register write or on leaving self refresh, a lock counter runs. New commands are refused until it expires. A refused command is dropped and sets a sticky violation flag.

Top module: `dram_cmd_frontend`

## Requirements
- R1: After reset, `cmd_ready`, `col_valid`, `rds_active`, `rd_strobe_split` and `lock_violation` are 0, `strobe_diff` is 1, the loop is off and the additive latency is 0.
- R2: `cmd_op` codes are 0 no-op, 1 activate, 2 read, 3 write, 4 extended mode write, 5 self-refresh entry, 6 self-refresh exit. In an extended mode write, address bit 0 set to 0 turns the loop on and set to 1 turns it off. `cmd_ready` is 0 while the loop is off.
- R3: A mode write that turns the loop on from off holds `cmd_ready` at 0 for the next 200 cycles. `cmd_ready` rises in the cycle after those 200 cycles.
- R4: An accepted self-refresh entry clears `cmd_ready` from the next cycle. A self-refresh exit with the loop set on starts a fresh 200-cycle lock wait.
- R5: Address bits 5:3 of a mode write give the additive latency as a binary number from 0 to 5. Codes 6 and 7 leave the previous latency in place.
- R6: With latency N>0, an accepted read or write appears on `col_valid` exactly N cycles after it is taken, with the same bank, address and direction. Commands leave in arrival order.
- R7: With latency 0, an accepted read or write appears on the column port in the cycle it arrives.
- R8: Address bit 10 of a mode write set to 0 selects the differential strobe (`strobe_diff`=1). Set to 1, it selects the single-ended strobe.
- R9: Address bit 11 of a mode write set to 0 enables the split read strobe (`rd_strobe_split`=1), but only in the x8 build. `rds_active` is high only for released reads while the split is on, and never for writes.
- R10: Any command other than a no-op that is not accepted is dropped and sets `lock_violation`, which then stays set until reset. Mode writes are accepted when neither locking nor in self refresh. Exit is accepted only in self refresh. All other commands need `cmd_ready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 3 | Command code (see R2) |
| cmd_bank | input | BANK_W | Bank of the command |
| cmd_addr | input | ADDR_W | Address / mode field bits |
| cmd_ready | output | 1 | Loop locked, commands may be issued |
| col_valid | output | 1 | Internal column command released |
| col_is_wr | output | 1 | Released command is a write |
| col_bank | output | BANK_W | Bank of released command |
| col_addr | output | ADDR_W | Address of released command |
| strobe_diff | output | 1 | Differential strobe selected |
| rd_strobe_split | output | 1 | Upper data bits follow the read strobe |
| rds_active | output | 1 | Read strobe driven for the released read |
| lock_violation | output | 1 | Sticky: a command was dropped |

## Verification
Suppose the lock counter is loaded wrong or decrements wrong. Then `cmd_ready` rises in the wrong cycle, and the reference model shows the mismatch on the first affected cycle, about 200 cycles after the enable. A wrong latency register or a slip in the hold pipeline moves `col_valid` off its expected cycle. It can also swap bank and address between queued commands, which shows the first time a held command is due. A wrongly decoded mode bit shows at once on the strobe flags, or on `rds_active` at the next released read.

// File: rtl/pcf_pkg.sv
`timescale 1ns/1ps
// Shared command codes and mode-field positions for the column front end.
// Assumes the command bus is already decoded into the 3-bit op code.
package pcf_pkg;
    typedef enum logic [2:0] {
        OP_NOP  = 3'd0,
        OP_ACT  = 3'd1,
        OP_RD   = 3'd2,
        OP_WR   = 3'd3,
        OP_EMRS = 3'd4,
        OP_SRE  = 3'd5,
        OP_SRX  = 3'd6
    } op_e;

    localparam int EMR_DLL_BIT   = 0;   // 0 = loop on
    localparam int EMR_AL_LO     = 3;   // 3-bit latency field base
    localparam int EMR_AL_BITS   = 3;
    localparam int EMR_STB_BIT   = 10;  // 0 = differential strobe
    localparam int EMR_SPLIT_BIT = 11;  // 0 = split read strobe
endpackage

// File: rtl/pcf_lock_gate.sv
`timescale 1ns/1ps
// Loop state, self-refresh state and relock counter.
// Produces the ready flag that gates command acceptance.
// Assumes the take strobes are already qualified by the acceptance rules.
module pcf_lock_gate #(
    parameter int LOCK_CYCLES = 200
) (
    input  logic clk,
    input  logic rst_n,
    input  logic emrs_take,
    input  logic emrs_dll_req,
    input  logic sre_take,
    input  logic srx_take,
    output logic dll_on,
    output logic in_sr,
    output logic locking,
    output logic ready
);
    localparam int CNT_W = $clog2(LOCK_CYCLES + 1);

    logic [CNT_W-1:0] cnt_q;
    logic             dll_q;
    logic             sr_q;
    logic             relock;

    // Relock whenever the loop goes from off to on, or self refresh ends with loop set on.
    assign relock = (emrs_take && emrs_dll_req && !dll_q) || (srx_take && dll_q);

    // Lock counter: reload on relock, otherwise count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (relock) begin
            cnt_q <= CNT_W'(LOCK_CYCLES);
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    // Loop enable setting and self-refresh state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dll_q <= 1'b0;
            sr_q  <= 1'b0;
        end else begin
            if (emrs_take) dll_q <= emrs_dll_req;
            if (sre_take)      sr_q <= 1'b1;
            else if (srx_take) sr_q <= 1'b0;
        end
    end

    assign dll_on  = dll_q;
    assign in_sr   = sr_q;
    assign locking = (cnt_q != '0);
    assign ready   = dll_q && !sr_q && (cnt_q == '0);
endmodule

// File: rtl/pcf_mode_regs.sv
`timescale 1ns/1ps
// Decodes accepted extended mode writes into latency and strobe settings.
// Latency codes above MAX_AL are refused; the split strobe exists only for x8.
module pcf_mode_regs
    import pcf_pkg::*;
#(
    parameter int ADDR_W = 14,
    parameter int MAX_AL = 5,
    parameter int AL_W   = 3,
    parameter int DQ_W   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              emrs_take,
    input  logic [ADDR_W-1:0] addr,
    output logic [AL_W-1:0]   al,
    output logic              stb_single,
    output logic              split_on
);
    logic [EMR_AL_BITS-1:0] al_code;
    logic [AL_W-1:0]        al_q;
    logic                   stb_q;
    logic                   nosplit_q;

    assign al_code = addr[EMR_AL_LO +: EMR_AL_BITS];

    // Capture the mode fields; refuse out-of-range latency codes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            al_q      <= '0;
            stb_q     <= 1'b0;
            nosplit_q <= 1'b1;
        end else if (emrs_take) begin
            if (int'(al_code) <= MAX_AL) al_q <= AL_W'(al_code);
            stb_q     <= addr[EMR_STB_BIT];
            nosplit_q <= addr[EMR_SPLIT_BIT];
        end
    end

    assign al         = al_q;
    assign stb_single = stb_q;

    generate
        if (DQ_W == 8) begin : g_x8
            assign split_on = !nosplit_q;
        end else begin : g_other
            assign split_on = 1'b0;
        end
    endgenerate
endmodule

// File: rtl/pcf_col_delay.sv
`timescale 1ns/1ps
// Holds accepted column commands for the programmed latency.
// The shift pipeline has one slot per cycle. An entry enters at slot al-1 and leaves from slot 0.
// Assumes latency only changes while the pipeline is empty.
module pcf_col_delay #(
    parameter int BANK_W = 3,
    parameter int ADDR_W = 14,
    parameter int MAX_AL = 5,
    parameter int AL_W   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              col_take,
    input  logic              col_wr,
    input  logic [BANK_W-1:0] bank,
    input  logic [ADDR_W-1:0] addr,
    input  logic [AL_W-1:0]   al,
    output logic              out_valid,
    output logic              out_wr,
    output logic [BANK_W-1:0] out_bank,
    output logic [ADDR_W-1:0] out_addr
);
    logic pass_now;
    assign pass_now = col_take && (al == '0);

    generate
        if (MAX_AL > 0) begin : g_pipe
            logic [MAX_AL-1:0] st_v;
            logic [MAX_AL-1:0] st_w;
            logic [BANK_W-1:0] st_b [MAX_AL];
            logic [ADDR_W-1:0] st_a [MAX_AL];

            // Shift toward slot 0; a new entry lands at slot al-1.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    st_v <= '0;
                end else begin
                    for (int k = 0; k < MAX_AL; k++) begin
                        if (col_take && (al != '0) && (k == int'(al) - 1)) begin
                            st_v[k] <= 1'b1;
                            st_w[k] <= col_wr;
                            st_b[k] <= bank;
                            st_a[k] <= addr;
                        end else if (k < MAX_AL - 1) begin
                            st_v[k] <= st_v[k+1];
                            st_w[k] <= st_w[k+1];
                            st_b[k] <= st_b[k+1];
                            st_a[k] <= st_a[k+1];
                        end else begin
                            st_v[k] <= 1'b0;
                        end
                    end
                end
            end

            // Output: held entry first, otherwise a zero-latency pass-through.
            always_comb begin
                if (st_v[0]) begin
                    out_valid = 1'b1;
                    out_wr    = st_w[0];
                    out_bank  = st_b[0];
                    out_addr  = st_a[0];
                end else begin
                    out_valid = pass_now;
                    out_wr    = col_wr;
                    out_bank  = bank;
                    out_addr  = addr;
                end
            end
        end else begin : g_direct
            assign out_valid = pass_now;
            assign out_wr    = col_wr;
            assign out_bank  = bank;
            assign out_addr  = addr;
        end
    endgenerate
endmodule

// File: rtl/dram_cmd_frontend.sv
`timescale 1ns/1ps
// Device-side command front end: mode decode, lock gating and posted column delay.
// Assumes one decoded command per cycle and latency changes only while idle.
module dram_cmd_frontend
    import pcf_pkg::*;
#(
    parameter int BANK_W      = 3,
    parameter int ADDR_W      = 14,
    parameter int MAX_AL      = 5,
    parameter int LOCK_CYCLES = 200,
    parameter int DQ_W        = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [2:0]        cmd_op,
    input  logic [BANK_W-1:0] cmd_bank,
    input  logic [ADDR_W-1:0] cmd_addr,
    output logic              cmd_ready,
    output logic              col_valid,
    output logic              col_is_wr,
    output logic [BANK_W-1:0] col_bank,
    output logic [ADDR_W-1:0] col_addr,
    output logic              strobe_diff,
    output logic              rd_strobe_split,
    output logic              rds_active,
    output logic              lock_violation
);
    localparam int AL_W = ($clog2(MAX_AL + 1) < 1) ? 1 : $clog2(MAX_AL + 1);

    op_e             op;
    logic            dll_on, in_sr, locking, ready;
    logic            take, drop, emrs_take, sre_take, srx_take, col_take;
    logic [AL_W-1:0] al;
    logic            stb_single, split_on;
    logic            viol_q;

    assign op = op_e'(cmd_op);

    // Acceptance rules per command class.
    always_comb begin
        unique case (op)
            OP_ACT, OP_RD, OP_WR, OP_SRE: take = cmd_valid && ready;
            OP_EMRS:                      take = cmd_valid && !in_sr && !locking;
            OP_SRX:                       take = cmd_valid && in_sr;
            default:                      take = 1'b0;
        endcase
    end

    assign drop      = cmd_valid && (op != OP_NOP) && !take;
    assign emrs_take = take && (op == OP_EMRS);
    assign sre_take  = take && (op == OP_SRE);
    assign srx_take  = take && (op == OP_SRX);
    assign col_take  = take && ((op == OP_RD) || (op == OP_WR));

    pcf_lock_gate #(.LOCK_CYCLES(LOCK_CYCLES)) u_gate (
        .clk          (clk),
        .rst_n        (rst_n),
        .emrs_take    (emrs_take),
        .emrs_dll_req (!cmd_addr[EMR_DLL_BIT]),
        .sre_take     (sre_take),
        .srx_take     (srx_take),
        .dll_on       (dll_on),
        .in_sr        (in_sr),
        .locking      (locking),
        .ready        (ready)
    );

    pcf_mode_regs #(.ADDR_W(ADDR_W), .MAX_AL(MAX_AL), .AL_W(AL_W), .DQ_W(DQ_W)) u_mode (
        .clk        (clk),
        .rst_n      (rst_n),
        .emrs_take  (emrs_take),
        .addr       (cmd_addr),
        .al         (al),
        .stb_single (stb_single),
        .split_on   (split_on)
    );

    pcf_col_delay #(.BANK_W(BANK_W), .ADDR_W(ADDR_W), .MAX_AL(MAX_AL), .AL_W(AL_W)) u_delay (
        .clk       (clk),
        .rst_n     (rst_n),
        .col_take  (col_take),
        .col_wr    (op == OP_WR),
        .bank      (cmd_bank),
        .addr      (cmd_addr),
        .al        (al),
        .out_valid (col_valid),
        .out_wr    (col_is_wr),
        .out_bank  (col_bank),
        .out_addr  (col_addr)
    );

    // Sticky record of any dropped command.
    always_ff @(posedge clk) begin
        if (!rst_n) viol_q <= 1'b0;
        else if (drop) viol_q <= 1'b1;
    end

    assign cmd_ready       = ready;
    assign strobe_diff     = !stb_single;
    assign rd_strobe_split = split_on;
    assign rds_active      = col_valid && !col_is_wr && split_on;
    assign lock_violation  = viol_q;
endmodule

// File: rtl/pcf_frontend_chk.sv
`timescale 1ns/1ps
// Assertion checker for the column front end, attached by bind.
module pcf_frontend_chk
    import pcf_pkg::*;
#(
    parameter int MAX_AL = 5,
    parameter int AL_W   = 3
) (
    input logic            clk,
    input logic            rst_n,
    input logic            cmd_valid,
    input logic [2:0]      cmd_op,
    input logic            cmd_ready,
    input logic            col_valid,
    input logic            col_is_wr,
    input logic            rds_active,
    input logic            lock_violation,
    input logic            dll_on,
    input logic [AL_W-1:0] al
);
    // R7
    al_zero_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready && al == '0 && (cmd_op == OP_RD || cmd_op == OP_WR)) |-> col_valid);

    // R10
    drop_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == OP_RD && !cmd_ready) |=> lock_violation);

    // R10
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lock_violation |=> lock_violation);

    // R9
    no_write_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (col_valid && col_is_wr) |-> !rds_active);

    // R4
    sr_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == OP_SRE && cmd_ready) |=> !cmd_ready);

    // R2
    dll_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !dll_on |-> !cmd_ready);

    // R5
    al_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int'(al) <= MAX_AL);
endmodule

bind dram_cmd_frontend pcf_frontend_chk #(.MAX_AL(MAX_AL), .AL_W(AL_W)) chk_i (
    .clk            (clk),
    .rst_n          (rst_n),
    .cmd_valid      (cmd_valid),
    .cmd_op         (cmd_op),
    .cmd_ready      (cmd_ready),
    .col_valid      (col_valid),
    .col_is_wr      (col_is_wr),
    .rds_active     (rds_active),
    .lock_violation (lock_violation),
    .dll_on         (dll_on),
    .al             (al)
);

// File: tb/dram_cmd_frontend_tb_top.sv
`timescale 1ns/1ps
// Bench: behavioural reference model compared against the ports every cycle.
module dram_cmd_frontend_tb_top;
    localparam int BANK_W = 3;
    localparam int ADDR_W = 14;
    localparam int MAX_AL = 5;
    localparam int LOCK   = 200;
    localparam int DQ_W   = 8;

    localparam int NOP = 0, ACT = 1, RD = 2, WR = 3, EMRS = 4, SRE = 5, SRX = 6;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic              rst_n;
    logic              cmd_valid;
    logic [2:0]        cmd_op;
    logic [BANK_W-1:0] cmd_bank;
    logic [ADDR_W-1:0] cmd_addr;
    logic              cmd_ready, col_valid, col_is_wr;
    logic [BANK_W-1:0] col_bank;
    logic [ADDR_W-1:0] col_addr;
    logic              strobe_diff, rd_strobe_split, rds_active, lock_violation;

    dram_cmd_frontend #(.BANK_W(BANK_W), .ADDR_W(ADDR_W), .MAX_AL(MAX_AL),
                        .LOCK_CYCLES(LOCK), .DQ_W(DQ_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_bank(cmd_bank), .cmd_addr(cmd_addr), .cmd_ready(cmd_ready),
        .col_valid(col_valid), .col_is_wr(col_is_wr), .col_bank(col_bank),
        .col_addr(col_addr), .strobe_diff(strobe_diff),
        .rd_strobe_split(rd_strobe_split), .rds_active(rds_active),
        .lock_violation(lock_violation)
    );

    int total = 0;
    int bad   = 0;
    int cyc   = 0;

    // Reference model state.
    bit m_dll = 0, m_sr = 0, m_a10 = 0, m_a11 = 1, m_viol = 0;
    int m_lock = 0, m_al = 0;
    typedef struct { int due; bit wr; int bank; int addr; } pend_t;
    pend_t q[$];

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s cycle %0d: actual=%0h expected=%0h", req, what, cyc, act, exp);
        end
    endtask

    function automatic int emrs(bit dll_off, int al, bit a10, bit a11);
        return int'(dll_off) | (al << 3) | (int'(a10) << 10) | (int'(a11) << 11);
    endfunction

    // One cycle: drive, compare the model's outputs for this cycle, then advance the model.
    task automatic step(input int op, input int bank, input int addr);
        bit exp_ready, take, colnow, exp_v, exp_wr, found, split;
        int exp_b, exp_a, code;
        string ctag;
        @(negedge clk);
        cmd_valid = (op != NOP);
        cmd_op    = 3'(op);
        cmd_bank  = BANK_W'(bank);
        cmd_addr  = ADDR_W'(addr);
        #5;
        exp_ready = m_dll && !m_sr && (m_lock == 0);
        case (op)
            ACT, RD, WR, SRE: take = exp_ready;
            EMRS:             take = !m_sr && (m_lock == 0);
            SRX:              take = m_sr;
            default:          take = 0;
        endcase
        colnow = take && (op == RD || op == WR);
        found = 0; exp_v = 0; exp_wr = 0; exp_b = 0; exp_a = 0;
        foreach (q[i]) if (q[i].due == cyc) begin
            found = 1; exp_v = 1; exp_wr = q[i].wr; exp_b = q[i].bank; exp_a = q[i].addr;
        end
        if (!found && colnow && m_al == 0) begin
            exp_v = 1; exp_wr = (op == WR); exp_b = bank; exp_a = addr;
        end
        ctag  = found ? "R6" : "R7";
        split = (DQ_W == 8) && !m_a11;
        chk("R3", "cmd_ready", 32'(cmd_ready), 32'(exp_ready));
        chk(ctag, "col_valid", 32'(col_valid), 32'(exp_v));
        if (exp_v) begin
            chk(ctag, "col_is_wr", 32'(col_is_wr), 32'(exp_wr));
            chk(ctag, "col_bank", 32'(col_bank), 32'(exp_b));
            chk(ctag, "col_addr", 32'(col_addr), 32'(exp_a));
        end
        chk("R8", "strobe_diff", 32'(strobe_diff), 32'(!m_a10));
        chk("R9", "rd_strobe_split", 32'(rd_strobe_split), 32'(split));
        chk("R9", "rds_active", 32'(rds_active), 32'(exp_v && !exp_wr && split));
        chk("R10", "lock_violation", 32'(lock_violation), 32'(m_viol));
        @(posedge clk);
        #1;
        if (colnow && m_al > 0) q.push_back('{cyc + m_al, (op == WR), bank, addr});
        for (int i = q.size() - 1; i >= 0; i--) if (q[i].due == cyc) q.delete(i);
        if (op != NOP && !take) m_viol = 1;
        if (m_lock > 0) m_lock--;
        if (take && op == EMRS) begin
            if (!addr[0] && !m_dll) m_lock = LOCK;
            m_dll = !addr[0];
            m_a10 = addr[10];
            m_a11 = addr[11];
            code  = (addr >> 3) & 7;
            if (code <= MAX_AL) m_al = code;
        end
        if (take && op == SRE) m_sr = 1;
        if (take && op == SRX) begin
            m_sr = 0;
            if (m_dll) m_lock = LOCK;
        end
        cyc++;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(NOP, 0, 0);
    endtask

    initial begin
        #4000000;
        total++; bad++;
        $display("FAIL watchdog: run did not finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst_n = 0; cmd_valid = 0; cmd_op = '0; cmd_bank = '0; cmd_addr = '0;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1", "cmd_ready", 32'(cmd_ready), 0);
        chk("R1", "col_valid", 32'(col_valid), 0);
        chk("R1", "strobe_diff", 32'(strobe_diff), 1);
        chk("R1", "rd_strobe_split", 32'(rd_strobe_split), 0);
        chk("R1", "rds_active", 32'(rds_active), 0);
        chk("R1", "lock_violation", 32'(lock_violation), 0);
        rst_n = 1;
        idle(2);
        // R2/R3: turn loop on, wait out the lock
        step(EMRS, 0, emrs(0, 0, 0, 1));
        idle(LOCK + 3);
        // R7: zero latency
        step(RD, 1, 14'h0123);
        step(WR, 2, 14'h0456);
        step(NOP, 0, 0);
        // R5/R6: latency 3, spaced commands keep order
        step(EMRS, 0, emrs(0, 3, 0, 1));
        step(RD, 3, 14'h0111);
        step(NOP, 0, 0);
        step(WR, 4, 14'h0222);
        step(NOP, 0, 0);
        step(RD, 5, 14'h0333);
        idle(6);
        // R6: latency 5
        step(EMRS, 0, emrs(0, 5, 0, 1));
        step(RD, 6, 14'h0aaa);
        idle(3);
        step(WR, 7, 14'h0bbb);
        idle(8);
        // R5: code 7 refused; R8: single-ended strobe
        step(EMRS, 0, emrs(0, 7, 1, 1));
        step(RD, 1, 14'h0ccc);
        idle(7);
        // R9: split strobe with latency 1
        step(EMRS, 0, emrs(0, 1, 1, 0));
        step(RD, 2, 14'h0d01);
        step(WR, 3, 14'h0d02);
        step(RD, 4, 14'h0d03);
        idle(3);
        // R5: code 6 refused, latency stays 1
        step(EMRS, 0, emrs(0, 6, 0, 0));
        step(WR, 5, 14'h0e01);
        idle(3);
        // R4/R10: self refresh, dropped read, relock, dropped mode write
        step(SRE, 0, 0);
        step(NOP, 0, 0);
        step(RD, 6, 14'h0f00);
        step(SRX, 0, 0);
        idle(10);
        step(EMRS, 0, emrs(0, 2, 0, 0));
        idle(LOCK - 8);
        step(RD, 7, 14'h0f11);
        idle(3);
        // R2: loop off blocks commands, turning on relocks
        step(EMRS, 0, emrs(1, 1, 0, 0));
        step(RD, 0, 14'h0123);
        step(EMRS, 0, emrs(0, 0, 0, 0));
        idle(LOCK + 2);
        step(WR, 2, 14'h1abc);
        step(ACT, 1, 14'h0001);
        idle(2);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule